// File: doc/BRIEF.md
# Lookup-Table Logic Cell

This block is a reprogrammable logic cell. A 16-bit truth table held in configuration registers decides what the cell computes from its four data inputs. In whole mode the table is one function of all four inputs, and both outputs carry that function. In split mode the table holds two separate functions of the three low inputs: the low half of the table drives output F and the high half drives output G. The top input has no effect in split mode.

Each output has its own source bit. That bit picks either the combinational table result or a copy of that result registered on the cell clock. The two flip-flops reset synchronously to zero.

The configuration can be loaded one word at a time on a parallel port, or one bit per clock on a serial port. A serial load only takes effect once the whole word has arrived. A new configuration becomes active at a clock edge, so the outputs never change partway through a cycle because of a configuration write.

Top module: `lut_logic_cell`

## Requirements
- R1: In whole mode (mode bit 16 = 0), with both outputs combinational, f_out and g_out both equal table bit number `din` (the four inputs read as an unsigned index, din[0] least significant).
- R2: In split mode (mode bit 16 = 1), f_out equals table bit {0, din[2:0]} and g_out equals table bit {1, din[2:0]}. din[3] has no effect on either output.
- R3: Configuration bit 17 selects the source of f_out and bit 18 selects the source of g_out. A source bit of 0 gives the combinational result. A source bit of 1 gives the result registered at the previous rising clock edge.
- R4: A parallel write (cfg_wr = 1, cfg_par = 1) replaces the whole configuration word at that rising edge. Bits 15:0 are the table, bit 16 is the mode and bits 18:17 are the source selects. The outputs show the old configuration until that edge.
- R5: A serial write (cfg_wr = 1, cfg_par = 0) shifts in one bit of cfg_sdata per edge, least significant bit first. The active configuration changes only at the edge that takes the 19th bit, and it then becomes the assembled word. A partial load leaves the outputs unchanged. A parallel write discards any partial serial load.
- R6: A synchronous active-high rst clears both flip-flops, the configuration and the serial bit count to zero.
- R7: When cfg_wr = 0, the active configuration holds, whatever values cfg_pdata and cfg_sdata carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 4 | Data inputs used as the table index |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_par | input | 1 | 1 = parallel word write, 0 = serial bit write |
| cfg_pdata | input | 19 | Parallel configuration word |
| cfg_sdata | input | 1 | Serial configuration bit |
| f_out | output | 1 | Output F |
| g_out | output | 1 | Output G |

## Verification
The assertions check the following on every cycle:
- the configuration holds without a write, and a partial serial load leaves it alone;
- the serial bit count stays in range;
- a registered output equals the function value from the previous cycle;
- the two outputs agree in combinational whole mode;
- in combinational split mode, F does not move when only din[3] changes.

Other behaviour needs the bench's scenarios:
- the actual truth-table contents behind each output, under several known functions;
- the exact edge at which a parallel or a completed serial load takes effect;
- the reset clearing the configuration.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  typedef enum logic {
    MODE_WHOLE = 1'b0,
    MODE_SPLIT = 1'b1
  } lut_mode_e;

  typedef enum logic {
    SRC_COMB = 1'b0,
    SRC_FLOP = 1'b1
  } out_src_e;

  localparam int unsigned NUM_OUT = 2;
  localparam int unsigned OUT_F   = 0;
  localparam int unsigned OUT_G   = 1;

endpackage

// File: rtl/lut_cfg_loader.sv
module lut_cfg_loader #(
  parameter int unsigned IN_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_wr,
  input  logic                          cfg_par,
  input  logic [(1<<IN_W)+2:0]          cfg_pdata,
  input  logic                          cfg_sdata,
  output logic [(1<<IN_W)-1:0]          tbl,
  output lut_cell_pkg::lut_mode_e       mode,
  output logic [lut_cell_pkg::NUM_OUT-1:0] src_sel
);
  import lut_cell_pkg::*;

  localparam int unsigned TBL_BITS = 1 << IN_W;
  localparam int unsigned CFG_W    = TBL_BITS + 3;
  localparam int unsigned CNT_W    = $clog2(CFG_W);
  localparam int unsigned MODE_BIT = TBL_BITS;
  localparam int unsigned SRC_LSB  = TBL_BITS + 1;

  logic [CFG_W-1:0] active_q;
  logic [CFG_W-1:0] shadow_q;
  logic [CNT_W-1:0] cnt_q;

  // Decoded write events, brought out as named wires for the checks
  logic             par_wr;
  logic             ser_wr;
  logic             ser_last;
  logic [CFG_W-1:0] shadow_nxt;

  assign par_wr     = cfg_wr & cfg_par;
  assign ser_wr     = cfg_wr & ~cfg_par;
  assign ser_last   = ser_wr && (cnt_q == CNT_W'(CFG_W - 1));
  assign shadow_nxt = {cfg_sdata, shadow_q[CFG_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
      shadow_q <= '0;
      cnt_q    <= '0;
    end else if (par_wr) begin
      active_q <= cfg_pdata;
      cnt_q    <= '0;
    end else if (ser_wr) begin
      shadow_q <= shadow_nxt;
      if (ser_last) begin
        active_q <= shadow_nxt;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign tbl     = active_q[TBL_BITS-1:0];
  assign mode    = lut_mode_e'(active_q[MODE_BIT]);
  assign src_sel = active_q[SRC_LSB +: NUM_OUT];

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(CFG_W - 1));

  p_partial_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ser_wr && !ser_last) |=> $stable(active_q));

  p_serial_done_r5: assert property (@(posedge clk) disable iff (rst)
    ser_last |=> (cnt_q == '0));

  p_par_load_r4: assert property (@(posedge clk) disable iff (rst)
    par_wr |=> (active_q == $past(cfg_pdata)));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(active_q));

  p_cfg_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (active_q == '0 && cnt_q == '0));

endmodule

// File: rtl/lut_eval_core.sv
module lut_eval_core #(
  parameter int unsigned IN_W = 4
) (
  input  logic [(1<<IN_W)-1:0]             tbl,
  input  lut_cell_pkg::lut_mode_e          mode,
  input  logic [IN_W-1:0]                  din,
  output logic [lut_cell_pkg::NUM_OUT-1:0] fn
);
  import lut_cell_pkg::*;

  localparam int unsigned TBL_BITS = 1 << IN_W;
  localparam int unsigned HALF_W   = IN_W - 1;

  // Full-width lookup of one table bit
  function automatic logic pick_bit(input logic [TBL_BITS-1:0] t,
                                    input logic [IN_W-1:0] idx);
    return t[idx];
  endfunction

  // Index into one half of the table: the top index bit chooses the half
  function automatic logic [IN_W-1:0] half_index(input logic upper,
                                                 input logic [HALF_W-1:0] low);
    return {upper, low};
  endfunction

  logic whole_val;
  logic low_val;
  logic high_val;

  assign whole_val = pick_bit(tbl, din);
  assign low_val   = pick_bit(tbl, half_index(1'b0, din[HALF_W-1:0]));
  assign high_val  = pick_bit(tbl, half_index(1'b1, din[HALF_W-1:0]));

  always_comb begin
    if (mode == MODE_SPLIT) begin
      fn[OUT_F] = low_val;
      fn[OUT_G] = high_val;
    end else begin
      fn[OUT_F] = whole_val;
      fn[OUT_G] = whole_val;
    end
  end

endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] fn,
  input  logic [LANES-1:0] src_sel,
  output logic [LANES-1:0] q_ff,
  output logic [LANES-1:0] out
);
  import lut_cell_pkg::*;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) q_ff[i] <= 1'b0;
      else     q_ff[i] <= fn[i];
    end

    assign out[i] = (out_src_e'(src_sel[i]) == SRC_FLOP) ? q_ff[i] : fn[i];

    p_flop_clear_r6: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (q_ff[i] == 1'b0));
  end

endmodule

// File: rtl/lut_logic_cell.sv
module lut_logic_cell #(
  parameter int unsigned IN_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [IN_W-1:0]        din,
  input  logic                   cfg_wr,
  input  logic                   cfg_par,
  input  logic [(1<<IN_W)+2:0]   cfg_pdata,
  input  logic                   cfg_sdata,
  output logic                   f_out,
  output logic                   g_out
);
  import lut_cell_pkg::*;

  localparam int unsigned TBL_BITS = 1 << IN_W;
  localparam int unsigned HALF_W   = IN_W - 1;

  logic [TBL_BITS-1:0] tbl;
  lut_mode_e           mode;
  logic [NUM_OUT-1:0]  src_sel;
  logic [NUM_OUT-1:0]  fn;
  logic [NUM_OUT-1:0]  q_ff;
  logic [NUM_OUT-1:0]  outs;

  lut_cfg_loader #(.IN_W(IN_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_par   (cfg_par),
    .cfg_pdata (cfg_pdata),
    .cfg_sdata (cfg_sdata),
    .tbl       (tbl),
    .mode      (mode),
    .src_sel   (src_sel)
  );

  lut_eval_core #(.IN_W(IN_W)) u_core (
    .tbl  (tbl),
    .mode (mode),
    .din  (din),
    .fn   (fn)
  );

  lut_out_stage #(.LANES(NUM_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .fn      (fn),
    .src_sel (src_sel),
    .q_ff    (q_ff),
    .out     (outs)
  );

  assign f_out = outs[OUT_F];
  assign g_out = outs[OUT_G];

  p_whole_agree_r1: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WHOLE && src_sel == '0) |-> (f_out == g_out));

  p_split_ignores_top_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SPLIT && $stable(mode) && src_sel[OUT_F] == 1'b0 &&
     $stable(src_sel) && $stable(tbl) && $stable(din[HALF_W-1:0]))
    |-> $stable(f_out));

  p_reg_f_r3: assert property (@(posedge clk) disable iff (rst)
    (src_sel[OUT_F] && !$past(rst)) |-> (f_out == $past(fn[OUT_F])));

  p_reg_g_r3: assert property (@(posedge clk) disable iff (rst)
    (src_sel[OUT_G] && !$past(rst)) |-> (g_out == $past(fn[OUT_G])));

endmodule

// File: tb/tb_lut_logic_cell.sv
`timescale 1ns/1ps
module tb_lut_logic_cell;

  localparam int CFG_W = 19;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [3:0]       din = '0;
  logic             cfg_wr = 1'b0;
  logic             cfg_par = 1'b0;
  logic [CFG_W-1:0] cfg_pdata = '0;
  logic             cfg_sdata = 1'b0;
  logic             f_out, g_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lut_logic_cell dut (
    .clk(clk), .rst(rst), .din(din), .cfg_wr(cfg_wr), .cfg_par(cfg_par),
    .cfg_pdata(cfg_pdata), .cfg_sdata(cfg_sdata), .f_out(f_out), .g_out(g_out)
  );

  // Vector fields: {table[15:0], split, din[3:0], expected F, expected G}
  localparam logic [22:0] VEC [10] = '{
    {16'h8000, 1'b0, 4'hF, 1'b1, 1'b1},   // R1 four-input AND, all ones
    {16'h8000, 1'b0, 4'h7, 1'b0, 1'b0},   // R1 AND, top input low
    {16'h6996, 1'b0, 4'hB, 1'b1, 1'b1},   // R1 parity, three ones
    {16'h6996, 1'b0, 4'h5, 1'b0, 1'b0},   // R1 parity, two ones
    {16'h96E8, 1'b1, 4'h3, 1'b1, 1'b0},   // R2 majority / xor3
    {16'h96E8, 1'b1, 4'h7, 1'b1, 1'b1},   // R2
    {16'h96E8, 1'b1, 4'h4, 1'b0, 1'b1},   // R2
    {16'h96E8, 1'b1, 4'hC, 1'b0, 1'b1},   // R2 din[3] ignored
    {16'h96E8, 1'b1, 4'h0, 1'b0, 1'b0},   // R2
    {16'h96E8, 1'b0, 4'hC, 1'b1, 1'b1}    // R1 same table read whole
  };

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic par_load(input logic [CFG_W-1:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_par = 1'b1; cfg_pdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [CFG_W-1:0] sw;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    din = 4'hF;
    #1;
    check("R6 reset F", f_out, 1'b0);
    check("R6 reset G", g_out, 1'b0);

    // Vector walk
    for (int i = 0; i < 10; i++) begin
      par_load({2'b00, VEC[i][6], VEC[i][22:7]});
      din = VEC[i][5:2];
      #1;
      check("R1/R2 vector F", f_out, VEC[i][1]);
      check("R1/R2 vector G", g_out, VEC[i][0]);
    end

    // R7: no write, noisy config inputs; config is whole 96E8, din=C -> 1
    @(negedge clk);
    cfg_pdata = '0; cfg_sdata = 1'b1; cfg_par = 1'b0;
    repeat (3) @(negedge clk);
    cfg_par = 1'b1;
    @(negedge clk);
    #1;
    check("R7 hold F", f_out, 1'b1);
    check("R7 hold G", g_out, 1'b1);

    // R4: parallel write takes effect at its edge, not before
    @(negedge clk);
    cfg_wr = 1'b1; cfg_par = 1'b1; cfg_pdata = {3'b000, 16'h0000};
    #1;
    check("R4 before edge F", f_out, 1'b1);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
    check("R4 after edge F", f_out, 1'b0);

    // R3: F registered, G combinational, parity table
    din = 4'h0;
    par_load({1'b0, 1'b1, 1'b0, 16'h6996});
    @(negedge clk);
    din = 4'h1;
    #1;
    check("R3 comb G", g_out, 1'b1);
    check("R3 flop F old", f_out, 1'b0);
    @(negedge clk);
    #1;
    check("R3 flop F new", f_out, 1'b1);
    din = 4'h3;
    #1;
    check("R3 flop F holds", f_out, 1'b1);
    check("R3 comb G follows", g_out, 1'b0);
    @(negedge clk);
    #1;
    check("R3 flop F next", f_out, 1'b0);

    // R5: serial load of split 96E8, all combinational
    par_load('0);
    din = 4'h3;
    sw = {3'b001, 16'h96E8};
    for (int b = 0; b < CFG_W; b++) begin
      @(negedge clk);
      cfg_wr = 1'b1; cfg_par = 1'b0; cfg_sdata = sw[b];
      #1;
      if (b == CFG_W - 1) check("R5 partial no effect", f_out, 1'b0);
    end
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
    check("R5 serial F", f_out, 1'b1);
    check("R5 serial G", g_out, 1'b0);

    // R5: a parallel write discards a partial serial load
    for (int b = 0; b < 5; b++) begin
      @(negedge clk);
      cfg_wr = 1'b1; cfg_par = 1'b0; cfg_sdata = 1'b1;
    end
    @(negedge clk);
    cfg_par = 1'b1; cfg_pdata = '0;
    @(negedge clk);
    sw = {3'b000, 16'hFFFF};
    for (int b = 0; b < CFG_W; b++) begin
      cfg_wr = 1'b1; cfg_par = 1'b0; cfg_sdata = sw[b];
      @(negedge clk);
    end
    cfg_wr = 1'b0;
    #1;
    check("R5 restart after parallel", f_out, 1'b1);

    // R6: reset clears flops and configuration
    par_load({1'b1, 1'b1, 1'b0, 16'hFFFF});
    @(negedge clk);
    #1;
    check("R6 pre-reset F", f_out, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R6 flop F cleared", f_out, 1'b0);
    check("R6 flop G cleared", g_out, 1'b0);
    @(negedge clk);
    #1;
    check("R6 config cleared", f_out, 1'b0);

    finish_up();
  end

endmodule